// File: doc/BRIEF.md
# Tagged Sample FIFO with Oldest-Word Overwrite

This block buffers conversion results on their way to software. Each incoming sample is 12 bits wide and comes with a 4-bit tag that names the conversion step that produced it. The block packs the two into a 16-bit word and stores it in a 64-entry ring. Software drains the ring through a read port, and each read removes the word it returns. A word count is always available.

When the ring is full and a new sample arrives with no read in the same cycle, the block does not drop the new sample. It discards the oldest stored word, keeps the new one, and raises a sticky overrun flag. Each sample whose step requests a range check is compared against a programmable upper limit. A sample strictly above that limit raises a sticky out-of-range flag. The word that caused the event is always the most recently written one, and the block exposes it on a separate output so that software can inspect it without draining the ring.

The occupancy controller is a three-state machine:
- **EMPTY**, **PARTIAL** and **FULL** are the states.
- **FILL** moves EMPTY to PARTIAL on the first write.
- **TOP** moves PARTIAL to FULL when the last free slot is written.
- **OVERWRITE** keeps FULL when a write arrives without a read.
- **SWAP** keeps FULL when a write and a read arrive together.
- **SPILL** moves FULL to PARTIAL when a read arrives without a write.
- **DRAIN** moves PARTIAL to EMPTY when the last word is read.
- **HOLD** covers any other case that leaves the state unchanged.

Top module: `smp_tag_fifo`

## Requirements
- R1: A stored word holds the step tag in bits 15:12 and the sample in bits 11:0. Words leave the read port in the order they were written, oldest first.
- R2: `word_cnt` equals the number of stored words and stays between 0 and 64. A write alone raises it by one, a read alone lowers it by one, and both in the same cycle leave it unchanged.
- R3: A write with no read while 64 words are stored discards the oldest word, keeps the new one and leaves the count at 64. `irq_ovr` reads 1 one cycle later.
- R4: A write and a read in the same cycle while full return the oldest word, keep the count at 64 and do not set `irq_ovr`.
- R5: A read with `rd_en` high removes the oldest word. That word appears on `rd_data` one cycle later and stays there until the next read.
- R6: A read while empty sets `rd_data` to zero one cycle later and leaves the count at zero.
- R7: A sample written with `smp_chk`=1 and a value strictly greater than `lim_max` sets `irq_oor` one cycle later. A sample equal to the limit, or written with `smp_chk`=0, does not set it.
- R8: `newest` shows the most recently written word one cycle after the write.
- R9: Both flags stay set until cleared by writing 1 to their bit of `flag_clr`: bit 0 clears `irq_ovr` and bit 1 clears `irq_oor`. The clear takes effect one cycle later. If a flag is set and cleared in the same cycle, it ends up set. A clear of one bit does not touch the other flag.
- R10: After reset, `word_cnt`, `rd_data`, `newest`, `irq_ovr` and `irq_oor` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | A sample is presented this cycle |
| smp_code | input | 12 | Sample value |
| smp_tag | input | 4 | Step tag of the sample |
| smp_chk | input | 1 | The step of this sample requests the range check |
| lim_max | input | 12 | Upper limit for the range check |
| rd_en | input | 1 | Pop one word |
| flag_clr | input | 2 | Write-one-to-clear: bit 0 overrun, bit 1 out-of-range |
| rd_data | output | 16 | Last popped word, or zero after a read while empty |
| newest | output | 16 | Most recently written word |
| word_cnt | output | 7 | Number of stored words |
| irq_ovr | output | 1 | Sticky overrun flag |
| irq_oor | output | 1 | Sticky out-of-range flag |

## Verification
Every output of this block is registered once. A write, read or clear presented in one cycle therefore shows on `word_cnt`, `rd_data`, `newest` and both flags exactly one cycle later, and the value then holds until the next stimulus. The bench changes inputs 1 ns after a rising edge and checks 1 ns after the following rising edge, so each check falls on the first cycle in which its result is due. The overrun and simultaneous-access cases first fill the ring to exactly 64 words, so the boundary count is reached before the critical cycle.

// File: rtl/smpfifo_pkg.sv
package smpfifo_pkg;

    typedef enum logic [1:0] {
        OCC_EMPTY   = 2'd0,
        OCC_PARTIAL = 2'd1,
        OCC_FULL    = 2'd2
    } occ_state_t;

    localparam int unsigned CLR_OVR_BIT = 0;
    localparam int unsigned CLR_OOR_BIT = 1;

endpackage

// File: rtl/smpfifo_ctrl.sv
module smpfifo_ctrl
    import smpfifo_pkg::*;
#(
    parameter int unsigned DEPTH = 64,
    localparam int unsigned PTR_W = $clog2(DEPTH),
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_req,
    input  logic             rd_req,
    output logic             do_push,
    output logic             do_pop,
    output logic             rd_none,
    output logic             ovr_evt,
    output logic [PTR_W-1:0] wr_ptr,
    output logic [PTR_W-1:0] rd_ptr,
    output logic [CNT_W-1:0] count
);

    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

    occ_state_t       state_q;
    occ_state_t       state_d;
    logic [CNT_W-1:0] cnt_d;
    logic             adv_head;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_LAST) ? '0 : p + PTR_W'(1);
    endfunction

    // output decode: what this cycle's request does in the current state
    always_comb begin
        do_push  = 1'b0;
        do_pop   = 1'b0;
        rd_none  = 1'b0;
        ovr_evt  = 1'b0;
        adv_head = 1'b0;
        cnt_d    = count;
        state_d  = state_q;
        unique case (state_q)
            OCC_EMPTY: begin
                do_push = wr_req;
                rd_none = rd_req;
                if (wr_req) begin
                    cnt_d   = CNT_W'(1);
                    state_d = (CNT_FULL == CNT_W'(1)) ? OCC_FULL : OCC_PARTIAL;  // FILL
                end
            end
            OCC_PARTIAL: begin
                do_push  = wr_req;
                do_pop   = rd_req;
                adv_head = rd_req;
                if (wr_req && !rd_req) begin
                    cnt_d = count + CNT_W'(1);
                    if (cnt_d == CNT_FULL) state_d = OCC_FULL;              // TOP
                end else if (rd_req && !wr_req) begin
                    cnt_d = count - CNT_W'(1);
                    if (cnt_d == '0) state_d = OCC_EMPTY;                   // DRAIN
                end
            end
            OCC_FULL: begin
                do_push  = wr_req;
                do_pop   = rd_req;
                ovr_evt  = wr_req && !rd_req;                               // OVERWRITE
                adv_head = rd_req || wr_req;
                if (rd_req && !wr_req) begin
                    cnt_d   = count - CNT_W'(1);                            // SPILL
                    state_d = (cnt_d == '0) ? OCC_EMPTY : OCC_PARTIAL;
                end
            end
            default: begin
                state_d = OCC_EMPTY;
                cnt_d   = '0;
            end
        endcase
    end

    // state register with occupancy and pointers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= OCC_EMPTY;
            count   <= '0;
            wr_ptr  <= '0;
            rd_ptr  <= '0;
        end else begin
            state_q <= state_d;
            count   <= cnt_d;
            if (do_push) wr_ptr <= ptr_inc(wr_ptr);
            if (adv_head) rd_ptr <= ptr_inc(rd_ptr);
        end
    end

endmodule

// File: rtl/smpfifo_store.sv
module smpfifo_store #(
    parameter int unsigned DEPTH  = 64,
    parameter int unsigned WORD_W = 16,
    localparam int unsigned PTR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [PTR_W-1:0]  waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic              re,
    input  logic              re_none,
    input  logic [PTR_W-1:0]  raddr,
    output logic [WORD_W-1:0] rdata
);

    logic [WORD_W-1:0] cells [DEPTH];

    // the read uses the old cell value when a write hits the same slot
    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (re) begin
            rdata <= cells[raddr];
        end else if (re_none) begin
            rdata <= '0;
        end
    end

endmodule

// File: rtl/smpfifo_flags.sv
module smpfifo_flags
    import smpfifo_pkg::*;
#(
    parameter int unsigned SMP_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ovr_evt,
    input  logic             smp_valid,
    input  logic             smp_chk,
    input  logic [SMP_W-1:0] smp_code,
    input  logic [SMP_W-1:0] lim_max,
    input  logic [1:0]       flag_clr,
    output logic             irq_ovr,
    output logic             irq_oor
);

    logic oor_evt;

    assign oor_evt = smp_valid && smp_chk && (smp_code > lim_max);

    // a set in the same cycle as its clear wins
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_ovr <= 1'b0;
            irq_oor <= 1'b0;
        end else begin
            if (ovr_evt) irq_ovr <= 1'b1;
            else if (flag_clr[CLR_OVR_BIT]) irq_ovr <= 1'b0;
            if (oor_evt) irq_oor <= 1'b1;
            else if (flag_clr[CLR_OOR_BIT]) irq_oor <= 1'b0;
        end
    end

endmodule

// File: rtl/smp_tag_fifo.sv
module smp_tag_fifo #(
    parameter int unsigned SMP_W  = 12,
    parameter int unsigned TAG_W  = 4,
    parameter int unsigned DEPTH  = 64,
    localparam int unsigned WORD_W = SMP_W + TAG_W,
    localparam int unsigned PTR_W  = $clog2(DEPTH),
    localparam int unsigned CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_valid,
    input  logic [SMP_W-1:0]  smp_code,
    input  logic [TAG_W-1:0]  smp_tag,
    input  logic              smp_chk,
    input  logic [SMP_W-1:0]  lim_max,
    input  logic              rd_en,
    input  logic [1:0]        flag_clr,
    output logic [WORD_W-1:0] rd_data,
    output logic [WORD_W-1:0] newest,
    output logic [CNT_W-1:0]  word_cnt,
    output logic              irq_ovr,
    output logic              irq_oor
);

    logic              do_push;
    logic              do_pop;
    logic              rd_none;
    logic              ovr_evt;
    logic [PTR_W-1:0]  wr_ptr;
    logic [PTR_W-1:0]  rd_ptr;
    logic [WORD_W-1:0] in_word;

    assign in_word = {smp_tag, smp_code};

    smpfifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_req  (smp_valid),
        .rd_req  (rd_en),
        .do_push (do_push),
        .do_pop  (do_pop),
        .rd_none (rd_none),
        .ovr_evt (ovr_evt),
        .wr_ptr  (wr_ptr),
        .rd_ptr  (rd_ptr),
        .count   (word_cnt)
    );

    smpfifo_store #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (do_push),
        .waddr   (wr_ptr),
        .wdata   (in_word),
        .re      (do_pop),
        .re_none (rd_none),
        .raddr   (rd_ptr),
        .rdata   (rd_data)
    );

    smpfifo_flags #(.SMP_W(SMP_W)) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .ovr_evt   (ovr_evt),
        .smp_valid (smp_valid),
        .smp_chk   (smp_chk),
        .smp_code  (smp_code),
        .lim_max   (lim_max),
        .flag_clr  (flag_clr),
        .irq_ovr   (irq_ovr),
        .irq_oor   (irq_oor)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) newest <= '0;
        else if (smp_valid) newest <= in_word;
    end

endmodule

// File: rtl/smp_tag_fifo_chk.sv
module smp_tag_fifo_chk #(
    parameter int unsigned SMP_W  = 12,
    parameter int unsigned TAG_W  = 4,
    parameter int unsigned DEPTH  = 64,
    localparam int unsigned WORD_W = SMP_W + TAG_W,
    localparam int unsigned CNT_W  = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              smp_valid,
    input logic [SMP_W-1:0]  smp_code,
    input logic [TAG_W-1:0]  smp_tag,
    input logic              smp_chk,
    input logic [SMP_W-1:0]  lim_max,
    input logic              rd_en,
    input logic [1:0]        flag_clr,
    input logic [WORD_W-1:0] rd_data,
    input logic [WORD_W-1:0] newest,
    input logic [CNT_W-1:0]  word_cnt,
    input logic              irq_ovr,
    input logic              irq_oor
);

    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        word_cnt <= CNT_FULL);

    p_pop_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !smp_valid && word_cnt != '0) |=> word_cnt == $past(word_cnt) - CNT_W'(1));

    p_overwrite_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (word_cnt == CNT_FULL && smp_valid && !rd_en) |=> (irq_ovr && word_cnt == CNT_FULL));

    p_swap_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (word_cnt == CNT_FULL && smp_valid && rd_en && !irq_ovr) |=> (!irq_ovr && word_cnt == CNT_FULL));

    p_empty_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (word_cnt == '0 && rd_en && !smp_valid) |=> (rd_data == '0 && word_cnt == '0));

    p_range_hit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && smp_chk && smp_code > lim_max) |=> irq_oor);

    p_newest_r8: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |=> newest == $past({smp_tag, smp_code}));

    p_ovr_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ovr && !flag_clr[0]) |=> irq_ovr);

    p_oor_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_oor && !flag_clr[1]) |=> irq_oor);

endmodule

bind smp_tag_fifo smp_tag_fifo_chk #(.SMP_W(SMP_W), .TAG_W(TAG_W), .DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_valid (smp_valid),
    .smp_code  (smp_code),
    .smp_tag   (smp_tag),
    .smp_chk   (smp_chk),
    .lim_max   (lim_max),
    .rd_en     (rd_en),
    .flag_clr  (flag_clr),
    .rd_data   (rd_data),
    .newest    (newest),
    .word_cnt  (word_cnt),
    .irq_ovr   (irq_ovr),
    .irq_oor   (irq_oor)
);

// File: tb/sim_smp_tag_fifo.sv
`timescale 1ns/1ps
module sim_smp_tag_fifo;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_valid = 1'b0;
    logic [11:0] smp_code = '0;
    logic [3:0]  smp_tag = '0;
    logic        smp_chk = 1'b0;
    logic [11:0] lim_max = 12'hfff;
    logic        rd_en = 1'b0;
    logic [1:0]  flag_clr = '0;
    logic [15:0] rd_data;
    logic [15:0] newest;
    logic [6:0]  word_cnt;
    logic        irq_ovr;
    logic        irq_oor;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    smp_tag_fifo u0 (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_code(smp_code),
        .smp_tag(smp_tag), .smp_chk(smp_chk), .lim_max(lim_max), .rd_en(rd_en),
        .flag_clr(flag_clr), .rd_data(rd_data), .newest(newest),
        .word_cnt(word_cnt), .irq_ovr(irq_ovr), .irq_oor(irq_oor)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] mk(input int i);
        logic [11:0] c;
        c = 12'((i * 37 + 5) % 4096);
        return {4'(i), c};
    endfunction

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; smp_valid = 1'b0; rd_en = 1'b0; flag_clr = '0; smp_chk = 1'b0;
        cyc(); cyc();
        rst_n = 1'b1;
    endtask

    task automatic push(input logic [15:0] w, input logic chk_on, input logic rd);
        smp_valid = 1'b1; smp_tag = w[15:12]; smp_code = w[11:0]; smp_chk = chk_on; rd_en = rd;
        cyc();
        smp_valid = 1'b0; smp_chk = 1'b0; rd_en = 1'b0;
    endtask

    task automatic pop();
        rd_en = 1'b1;
        cyc();
        rd_en = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        check("R10 cnt", 32'(word_cnt), 0);
        check("R10 rd_data", 32'(rd_data), 0);
        check("R10 newest", 32'(newest), 0);
        check("R10 flags", {30'd0, irq_ovr, irq_oor}, 0);
    endtask

    task automatic t_order();
        do_reset();
        for (int i = 0; i < 5; i++) begin
            push(mk(i), 1'b0, 1'b0);
            check("R8 newest", 32'(newest), 32'(mk(i)));
        end
        check("R2 count after 5 writes", 32'(word_cnt), 5);
        push(mk(9), 1'b0, 1'b1);
        check("R5 read with write returns oldest", 32'(rd_data), 32'(mk(0)));
        check("R2 count same on write+read", 32'(word_cnt), 5);
        for (int i = 1; i < 5; i++) begin
            pop();
            check("R1 R5 fifo order and field layout", 32'(rd_data), 32'(mk(i)));
            check("R2 count after read", 32'(word_cnt), 32'(5 - i));
        end
        cyc();
        check("R5 rd_data holds", 32'(rd_data), 32'(mk(4)));
        pop();
        check("R1 last word", 32'(rd_data), 32'(mk(9)));
        check("R1 tag field bits 15:12", 32'(rd_data[15:12]), 9);
    endtask

    task automatic t_empty();
        do_reset();
        push(mk(7), 1'b0, 1'b0);
        pop();
        check("R5 single word", 32'(rd_data), 32'(mk(7)));
        pop();
        check("R6 empty read gives zero", 32'(rd_data), 0);
        check("R6 empty read count", 32'(word_cnt), 0);
    endtask

    task automatic t_overrun();
        do_reset();
        for (int i = 0; i < 64; i++) push(mk(i), 1'b0, 1'b0);
        check("R2 full count", 32'(word_cnt), 64);
        check("R3 no overrun at exactly full", 32'(irq_ovr), 0);
        for (int i = 64; i < 67; i++) push(mk(i), 1'b0, 1'b0);
        check("R3 count stays 64", 32'(word_cnt), 64);
        check("R3 overrun flag", 32'(irq_ovr), 1);
        for (int i = 3; i < 67; i++) begin
            pop();
            check("R3 oldest discarded", 32'(rd_data), 32'(mk(i)));
        end
        check("R2 drained", 32'(word_cnt), 0);
    endtask

    task automatic t_full_swap();
        do_reset();
        for (int i = 0; i < 64; i++) push(mk(100 + i), 1'b0, 1'b0);
        push(mk(200), 1'b0, 1'b1);
        check("R4 read returns oldest", 32'(rd_data), 32'(mk(100)));
        check("R4 count stays 64", 32'(word_cnt), 64);
        check("R4 no overrun", 32'(irq_ovr), 0);
        for (int i = 1; i < 64; i++) pop();
        check("R4 second-newest before new word", 32'(rd_data), 32'(mk(163)));
        pop();
        check("R4 new word kept", 32'(rd_data), 32'(mk(200)));
    endtask

    task automatic t_range();
        do_reset();
        lim_max = 12'h800;
        push({4'h2, 12'h800}, 1'b1, 1'b0);
        check("R7 equal to limit", 32'(irq_oor), 0);
        push({4'h3, 12'h801}, 1'b0, 1'b0);
        check("R7 check disabled", 32'(irq_oor), 0);
        push({4'h5, 12'h801}, 1'b1, 1'b0);
        check("R7 above limit", 32'(irq_oor), 1);
        check("R8 newest is offending sample", 32'(newest), 32'h5801);
        lim_max = 12'hfff;
    endtask

    task automatic t_clear();
        flag_clr = 2'b01;
        cyc();
        flag_clr = 2'b00;
        check("R9 other bit leaves oor", 32'(irq_oor), 1);
        lim_max = 12'h010;
        smp_valid = 1'b1; smp_code = 12'h020; smp_tag = 4'h1; smp_chk = 1'b1; flag_clr = 2'b10;
        cyc();
        smp_valid = 1'b0; smp_chk = 1'b0; flag_clr = 2'b00;
        check("R9 set wins over clear", 32'(irq_oor), 1);
        cyc();
        check("R9 sticky", 32'(irq_oor), 1);
        flag_clr = 2'b10;
        cyc();
        flag_clr = 2'b00;
        check("R9 w1c clears oor", 32'(irq_oor), 0);
        lim_max = 12'hfff;
    endtask

    initial begin
        #(200000 * 4);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_order();
        t_empty();
        t_overrun();
        t_full_swap();
        t_range();
        t_clear();
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule